// File: doc/BRIEF.md
# Parallel Range Rule Matcher

This block sits at the leaf stage of a packet classifier. A leaf of the search structure is one wide memory word holding up to thirty packed rules of 160 bits each. The block takes that word together with the five header fields of one packet. In a single cycle it compares the packet against every rule slot at once. A rule is judged on five things: two port ranges, two address prefixes and a protocol value that may be a wildcard.

A leaf does not always start at slot zero and is not always full. The caller therefore gives a start slot and a rule count, and only the slots in that window take part. Among the eligible slots that match, the one with the lowest slot number wins. The block returns a match flag and the absolute slot number of the winner, both registered one clock after the request.

Top module: `ruleMatchTop`

## Requirements
- R1: Slot s occupies bits [s*160+159 : s*160] of the leaf word. Within a slot, from bit 159 down: source address [159:128], source mask code [127:125], destination address [124:93], destination mask code [92:90], source port low [89:74], source port high [73:58], destination port low [57:42], destination port high [41:26], protocol value [25:18], protocol wildcard [17]. Bits [16:0] carry no meaning.
- R2: A port field matches when low ≤ packet port ≤ high, with both bounds inclusive.
- R3: For a mask code other than 7, the prefix length is the 6-bit value {code, address[2:0]}. For code 7, it is 28 plus address[2:0]. Only the leading min(length, 29) address bits are compared. Address bits [2:0] are never compared, and a length of 0 matches any address.
- R4: When the wildcard bit is 1, the protocol matches any value. When it is 0, the packet protocol must equal the stored value.
- R5: Slot s is eligible only when startPos ≤ s < startPos + ruleCnt and s < 30. A rule count of 0, or a window that lies wholly beyond slot 29, gives no match.
- R6: When several eligible slots match, matchIdx is the smallest matching slot number, given as an absolute slot number rather than an offset from startPos.
- R7: The clock edge that samples inValid high updates outValid, matchFlag and matchIdx. While inValid is low, outValid is 0, and matchFlag and matchIdx keep their values whatever the other inputs do.
- R8: When no eligible slot matches, matchFlag is 0 and matchIdx is 0.
- R9: After reset, outValid, matchFlag and matchIdx are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The request on the other inputs is to be evaluated |
| leafWord | input | 4800 | Packed rule slots, slot 0 in the low bits |
| srcIp | input | 32 | Packet source address |
| dstIp | input | 32 | Packet destination address |
| srcPort | input | 16 | Packet source port |
| dstPort | input | 16 | Packet destination port |
| proto | input | 8 | Packet protocol number |
| startPos | input | 5 | First eligible slot |
| ruleCnt | input | 5 | Number of eligible slots from startPos |
| outValid | output | 1 | Result registers were loaded on the last edge |
| matchFlag | output | 1 | Some eligible slot matched |
| matchIdx | output | 5 | Absolute slot number of the winning rule |

## Verification
The bench builds the block with its default of thirty slots, so the full 4800-bit word is in play. Start and count values up to 31 can therefore push the window past the last slot, and a count of 0 can leave it empty. With thirty slots the bench can also set up several simultaneous matches, which shows that the lowest slot wins. It can place hits at both ends of the word, and it can test prefix codes across the whole range, from a wildcard through the cap of 29 compared bits.

// File: rtl/ruleMatchPkg.sv
package ruleMatchPkg;

  localparam int RULE_W   = 160;
  localparam int ADDR_W   = 32;
  localparam int PORT_W   = 16;
  localparam int PROTO_W  = 8;
  localparam int CODE_W   = 3;
  localparam int MAX_CMP  = 29;

  // bit positions inside one rule slot
  localparam int SRC_ADDR_HI = 159;
  localparam int SRC_CODE_HI = SRC_ADDR_HI - ADDR_W;
  localparam int DST_ADDR_HI = SRC_CODE_HI - CODE_W;
  localparam int DST_CODE_HI = DST_ADDR_HI - ADDR_W;
  localparam int SP_LO_HI    = DST_CODE_HI - CODE_W;
  localparam int SP_HI_HI    = SP_LO_HI - PORT_W;
  localparam int DP_LO_HI    = SP_HI_HI - PORT_W;
  localparam int DP_HI_HI    = DP_LO_HI - PORT_W;
  localparam int PROTO_HI    = DP_HI_HI - PORT_W;
  localparam int WILD_BIT    = PROTO_HI - PROTO_W;
  localparam int USED_LO     = WILD_BIT;
  localparam int USED_W      = RULE_W - USED_LO;

  typedef struct packed {
    logic [ADDR_W-1:0]  srcIp;
    logic [ADDR_W-1:0]  dstIp;
    logic [PORT_W-1:0]  srcPort;
    logic [PORT_W-1:0]  dstPort;
    logic [PROTO_W-1:0] proto;
  } pktHdr_t;

  typedef struct packed {
    logic capture;
  } ctrlStrobes_t;

endpackage

// File: rtl/ruleSlotCmp.sv
module ruleSlotCmp
  import ruleMatchPkg::*;
(
  input  logic [USED_W-1:0] ruleBits,
  input  pktHdr_t           hdr,
  output logic              hit
);

  localparam int OFF = USED_LO;

  logic [ADDR_W-1:0]  srcAddr, dstAddr;
  logic [CODE_W-1:0]  srcCode, dstCode;
  logic [PORT_W-1:0]  spLow, spHigh, dpLow, dpHigh;
  logic [PROTO_W-1:0] protoVal;
  logic               protoWild;
  logic               srcOk, dstOk, spOk, dpOk, protoOk;

  function automatic logic prefixHit(input logic [ADDR_W-1:0] ruleAddr,
                                     input logic [CODE_W-1:0] code,
                                     input logic [ADDR_W-1:0] pktAddr);
    logic [5:0]        len;
    logic [5:0]        eff;
    logic [ADDR_W-1:0] care;
    if (code == 3'd7) len = 6'd28 + {3'b000, ruleAddr[2:0]};
    else              len = {code, ruleAddr[2:0]};
    eff = (len > 6'(MAX_CMP)) ? 6'(MAX_CMP) : len;
    for (int b = 0; b < ADDR_W; b++) care[b] = (b >= ADDR_W - int'(eff));
    return ((ruleAddr ^ pktAddr) & care) == '0;
  endfunction

  always_comb begin
    srcAddr   = ruleBits[SRC_ADDR_HI-OFF -: ADDR_W];
    srcCode   = ruleBits[SRC_CODE_HI-OFF -: CODE_W];
    dstAddr   = ruleBits[DST_ADDR_HI-OFF -: ADDR_W];
    dstCode   = ruleBits[DST_CODE_HI-OFF -: CODE_W];
    spLow     = ruleBits[SP_LO_HI-OFF -: PORT_W];
    spHigh    = ruleBits[SP_HI_HI-OFF -: PORT_W];
    dpLow     = ruleBits[DP_LO_HI-OFF -: PORT_W];
    dpHigh    = ruleBits[DP_HI_HI-OFF -: PORT_W];
    protoVal  = ruleBits[PROTO_HI-OFF -: PROTO_W];
    protoWild = ruleBits[WILD_BIT-OFF];
  end

  assign srcOk   = prefixHit(srcAddr, srcCode, hdr.srcIp);
  assign dstOk   = prefixHit(dstAddr, dstCode, hdr.dstIp);
  assign spOk    = (hdr.srcPort >= spLow) && (hdr.srcPort <= spHigh);
  assign dpOk    = (hdr.dstPort >= dpLow) && (hdr.dstPort <= dpHigh);
  assign protoOk = protoWild || (hdr.proto == protoVal);
  assign hit     = srcOk && dstOk && spOk && dpOk && protoOk;

endmodule

// File: rtl/ruleMatchCtrl.sv
module ruleMatchCtrl
  import ruleMatchPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  assign strobes.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R7

endmodule

// File: rtl/ruleMatchDatapath.sv
module ruleMatchDatapath
  import ruleMatchPkg::*;
#(
  parameter int SLOT_CNT = 30,
  localparam int WORD_W  = SLOT_CNT * RULE_W,
  localparam int IDX_W   = $clog2(SLOT_CNT),
  localparam int CNT_W   = $clog2(SLOT_CNT + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] leafWord,
  input  pktHdr_t           hdr,
  input  logic [IDX_W-1:0]  startPos,
  input  logic [CNT_W-1:0]  ruleCnt,
  output logic              matchFlag,
  output logic [IDX_W-1:0]  matchIdx
);

  localparam int END_W = (IDX_W > CNT_W ? IDX_W : CNT_W) + 1;

  logic [SLOT_CNT-1:0] hitVec, eligVec, candVec, winVec;
  logic [END_W-1:0]    endPos;
  logic                anyCand;
  logic [IDX_W-1:0]    nextIdx;

  assign endPos = END_W'(startPos) + END_W'(ruleCnt);

  for (genvar s = 0; s < SLOT_CNT; s++) begin : gSlot
    ruleSlotCmp uCmp (
      .ruleBits (leafWord[s*RULE_W + USED_LO +: USED_W]),
      .hdr      (hdr),
      .hit      (hitVec[s])
    );
    assign eligVec[s] = (END_W'(s) >= END_W'(startPos)) && (END_W'(s) < endPos);
  end

  assign candVec = hitVec & eligVec;
  assign anyCand = |candVec;
  assign winVec  = candVec & (~candVec + SLOT_CNT'(1));

  always_comb begin
    nextIdx = '0;
    for (int s = SLOT_CNT - 1; s >= 0; s--) begin
      if (candVec[s]) nextIdx = IDX_W'(s);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
      matchIdx  <= '0;
    end else if (strobes.capture) begin
      matchFlag <= anyCand;
      matchIdx  <= anyCand ? nextIdx : '0;
    end
  end

  AST_WIN_AGREES: assert property (@(posedge clk) disable iff (!rstN)
    anyCand |-> (winVec[nextIdx] && $onehot0(winVec)));  // R6
  AST_IDX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    anyCand |-> ((END_W'(nextIdx) >= END_W'(startPos)) && (END_W'(nextIdx) < endPos)));  // R5
  AST_NO_MATCH_IDX: assert property (@(posedge clk) disable iff (!rstN)
    !matchFlag |-> (matchIdx == '0));  // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(matchFlag) && $stable(matchIdx)));  // R7
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    matchFlag |-> (int'(matchIdx) < SLOT_CNT));  // R5

endmodule

// File: rtl/ruleMatchTop.sv
module ruleMatchTop
  import ruleMatchPkg::*;
#(
  parameter int SLOT_CNT = 30,
  localparam int WORD_W  = SLOT_CNT * RULE_W,
  localparam int IDX_W   = $clog2(SLOT_CNT),
  localparam int CNT_W   = $clog2(SLOT_CNT + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] leafWord,
  input  logic [31:0]       srcIp,
  input  logic [31:0]       dstIp,
  input  logic [15:0]       srcPort,
  input  logic [15:0]       dstPort,
  input  logic [7:0]        proto,
  input  logic [IDX_W-1:0]  startPos,
  input  logic [CNT_W-1:0]  ruleCnt,
  output logic              outValid,
  output logic              matchFlag,
  output logic [IDX_W-1:0]  matchIdx
);

  pktHdr_t      hdr;
  ctrlStrobes_t strobes;

  assign hdr = '{srcIp: srcIp, dstIp: dstIp, srcPort: srcPort,
                 dstPort: dstPort, proto: proto};

  ruleMatchCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  ruleMatchDatapath #(.SLOT_CNT(SLOT_CNT)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .leafWord  (leafWord),
    .hdr       (hdr),
    .startPos  (startPos),
    .ruleCnt   (ruleCnt),
    .matchFlag (matchFlag),
    .matchIdx  (matchIdx)
  );

endmodule

// File: tb/tb_ruleMatchTop.sv
module tb_ruleMatchTop;

  localparam int SLOTS = 30;
  localparam int WW    = SLOTS * 160;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [WW-1:0] leafWord = '0;
  logic [31:0]   srcIp = '0, dstIp = '0;
  logic [15:0]   srcPort = '0, dstPort = '0;
  logic [7:0]    proto = '0;
  logic [4:0]    startPos = '0, ruleCnt = '0;
  logic          outValid, matchFlag;
  logic [4:0]    matchIdx;

  int  testCnt = 0, failCnt = 0;
  bit  done = 0;
  bit  expValid = 0, expFlag = 0;
  int  expIdx = 0;

  always #2.5 clk = ~clk;

  ruleMatchTop dut (.*);

  // ---------------- behavioural reference ----------------
  function automatic bit ipOk(logic [31:0] a, logic [2:0] code, logic [31:0] p);
    int len;
    len = (code == 3'd7) ? 28 + int'(a[2:0]) : int'(code) * 8 + int'(a[2:0]);
    if (len > 29) len = 29;
    if (len == 0) return 1;
    return ((a ^ p) >> (32 - len)) == 0;
  endfunction

  function automatic bit ruleOk(logic [159:0] r);
    if (!ipOk(r[159:128], r[127:125], srcIp)) return 0;
    if (!ipOk(r[124:93], r[92:90], dstIp)) return 0;
    if (srcPort < r[89:74] || srcPort > r[73:58]) return 0;
    if (dstPort < r[57:42] || dstPort > r[41:26]) return 0;
    if (!r[17] && r[25:18] != proto) return 0;
    return 1;
  endfunction

  task automatic refModel(output bit f, output int idx);
    f = 0; idx = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!f && s >= int'(startPos) && s < int'(startPos) + int'(ruleCnt)
          && ruleOk(leafWord[s*160 +: 160])) begin
        f = 1; idx = s;
      end
    end
  endtask

  // ---------------- rule building ----------------
  function automatic logic [34:0] encIp(logic [31:0] a, int len);
    if (len <= 27) return {a[31:3], 3'(len), 3'(len >> 3)};
    return {a[31:3], 3'(len - 28), 3'd7};
  endfunction

  function automatic logic [159:0] mkRule(logic [31:0] sa, int sl, logic [31:0] da, int dl,
      logic [15:0] spl, logic [15:0] sph, logic [15:0] dpl, logic [15:0] dph,
      logic [7:0] pv, bit wild);
    return {encIp(sa, sl), encIp(da, dl), spl, sph, dpl, dph, pv, wild, 17'h0};
  endfunction

  // ---------------- checking ----------------
  task automatic check(string tag);
    testCnt++;
    if (outValid !== expValid || matchFlag !== expFlag || int'(matchIdx) != expIdx) begin
      failCnt++;
      $display("FAIL %s: got valid=%0b flag=%0b idx=%0d expected valid=%0b flag=%0b idx=%0d",
               tag, outValid, matchFlag, matchIdx, expValid, expFlag, expIdx);
    end
  endtask

  // inputs are already set; advance one edge and compare
  task automatic step(string tag);
    bit f; int idx;
    refModel(f, idx);
    @(posedge clk);
    expValid = inValid;
    if (inValid) begin expFlag = f; expIdx = idx; end
    #1 check(tag);
    @(negedge clk);
  endtask

  task automatic setHdr(logic [31:0] sa, logic [31:0] da, logic [15:0] sp,
                        logic [15:0] dp, logic [7:0] pr);
    srcIp = sa; dstIp = da; srcPort = sp; dstPort = dp; proto = pr;
  endtask

  task automatic expectDirect(bit f, int idx, string tag);
    testCnt++;
    if (matchFlag !== f || int'(matchIdx) != idx) begin
      failCnt++;
      $display("FAIL %s: got flag=%0b idx=%0d expected flag=%0b idx=%0d",
               tag, matchFlag, matchIdx, f, idx);
    end
  endtask

  localparam logic [31:0] SA = 32'h0A01_0203;
  localparam logic [31:0] DA = 32'hC0A8_0105;

  logic [159:0] baseRule;

  initial begin
    baseRule = mkRule(SA, 29, DA, 29, 16'd990, 16'd1000, 16'd80, 16'd80, 8'd6, 0);
    repeat (3) @(negedge clk);
    #1 check("R9 reset");
    rstN = 1'b1;
    @(negedge clk);

    // R1/R2: port bounds, single rule at slot 0
    leafWord = '0;
    leafWord[0 +: 160] = baseRule;
    startPos = 0; ruleCnt = 1; inValid = 1;
    setHdr(SA, DA, 16'd1000, 16'd80, 8'd6); step("R2 high bound");
    expectDirect(1, 0, "R2 high bound direct");
    srcPort = 16'd990;  step("R2 low bound");
    srcPort = 16'd989;  step("R2 below low");
    expectDirect(0, 0, "R8 miss gives idx 0");
    srcPort = 16'd1001; step("R2 above high");
    srcPort = 16'd995; dstPort = 16'd81; step("R2 dst port miss");

    // R3: prefix codes
    setHdr(SA, DA, 16'd995, 16'd80, 8'd6);
    leafWord[0 +: 160] = mkRule(SA, 24, DA, 0, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF, 8'd0, 1);
    srcIp = SA ^ 32'h0000_0080; step("R3 len24 outside prefix");
    expectDirect(1, 0, "R3 len24 direct");
    srcIp = SA ^ 32'h0000_0100; step("R3 len24 inside prefix");
    expectDirect(0, 0, "R3 len24 miss direct");
    srcIp = SA; dstIp = 32'hFFFF_FFFF; step("R3 len0 wildcard");
    leafWord[0 +: 160] = mkRule(SA, 29, DA, 32, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF, 8'd0, 1);
    dstIp = DA ^ 32'h7; step("R3 low bits ignored");
    expectDirect(1, 0, "R3 cap 29 direct");
    dstIp = DA ^ 32'h8; step("R3 bit3 compared");
    srcIp = SA ^ 32'h10; dstIp = DA; step("R3 code7 len29 miss");

    // R4: protocol
    leafWord[0 +: 160] = baseRule;
    setHdr(SA, DA, 16'd995, 16'd80, 8'd17); step("R4 exact miss");
    leafWord[0 +: 160] = mkRule(SA, 29, DA, 29, 16'd990, 16'd1000, 16'd80, 16'd80, 8'd6, 1);
    step("R4 wildcard hit");

    // R5/R6: window and priority
    leafWord = '0;
    leafWord[2*160 +: 160] = baseRule;
    leafWord[10*160 +: 160] = baseRule;
    leafWord[29*160 +: 160] = baseRule;
    proto = 8'd6;
    startPos = 0;  ruleCnt = 31; step("R6 lowest of three");
    expectDirect(1, 2, "R6 direct slot 2");
    startPos = 3;  ruleCnt = 10; step("R6 absolute index 10");
    expectDirect(1, 10, "R6 direct slot 10");
    startPos = 3;  ruleCnt = 7;  step("R5 window ends before 10");
    startPos = 11; ruleCnt = 19; step("R5 last slot 29");
    startPos = 2;  ruleCnt = 0;  step("R5 empty window");
    startPos = 30; ruleCnt = 31; step("R5 window past end");
    startPos = 29; ruleCnt = 1;  step("R5 single top slot");

    // R7: hold while idle
    inValid = 0; startPos = 0; ruleCnt = 31;
    step("R7 idle holds");
    leafWord = '0; step("R7 idle ignores word");
    expectDirect(1, 29, "R7 held result");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [159:0] r;
      setHdr($urandom, $urandom, 16'($urandom), 16'($urandom), 8'($urandom_range(0, 3)));
      for (int s = 0; s < SLOTS; s++) begin
        int sp0, dp0;
        sp0 = int'(srcPort) - int'($urandom_range(0, 40)) + 20;
        dp0 = int'(dstPort) - int'($urandom_range(0, 40)) + 20;
        if (sp0 < 0) sp0 = 0;
        if (dp0 < 0) dp0 = 0;
        if (sp0 > 65535) sp0 = 65535;
        if (dp0 > 65535) dp0 = 65535;
        r = mkRule(srcIp ^ (32'(1) << $urandom_range(0, 31)), int'($urandom_range(0, 32)),
                   dstIp ^ (($urandom_range(0, 1) == 1) ? 32'h0 : 32'(1) << $urandom_range(0, 31)),
                   int'($urandom_range(0, 32)),
                   16'(sp0), 16'(sp0 + 30 > 65535 ? 65535 : sp0 + 30),
                   16'(dp0), 16'(dp0 + 30 > 65535 ? 65535 : dp0 + 30),
                   8'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
        leafWord[s*160 +: 160] = r;
      end
      startPos = 5'($urandom); ruleCnt = 5'($urandom);
      inValid = ($urandom_range(0, 4) != 0);
      step("R1-mix R2 R3 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule